// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the sequencing engine of one DMA channel. Once started, it moves a programmed number of units from a source to a destination. Each unit is moved as a read phase followed by a write phase. Source and destination each have their own address register, which counts up, counts down or holds still. Either side may be marked as a narrow I/O device. A unit wider than that device's port is then broken into back-to-back port-width accesses, least significant part first.

The channel can take the shared bus in two ways. In snoop mode it borrows the processor's data path and never gives it up early. In handshake mode it raises a bus request and waits for a grant before any access. In handshake mode it can optionally hand the bus back when the processor asks. It does so only at the end of a whole unit, and it asks again once the processor withdraws the request. Each unit starts on a trigger. The trigger is either an internal request line or an external line, and the external line works on its level or on its rising edge.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, bus_rd, bus_wr, bus_req, snoop_req and done are all 0.
- R2: Each side's address mode works as follows: 2'b00 adds the access size in bytes after every access on that side, 2'b01 subtracts it, and 2'b10/2'b11 keep the address fixed.
- R3: The unit size field decodes 2'b11 as 1 byte, 2'b10 as 2 bytes and 2'b00/2'b01 as 4 bytes. bus_size reports each access as 2'b00 for a byte, 2'b01 for a half-word and 2'b10 for a word, and never 2'b11. A memory side makes one access per unit.
- R4: An I/O side whose port (same encoding as the unit size) is narrower than the unit makes unit/port accesses of port width in a row. All reads of a unit come before its writes, and bus_rd and bus_wr are never high together.
- R5: An I/O side whose port is as wide as the unit, or wider, makes a single access of unit size.
- R6: With the snoop bit at 0, the channel raises bus_req, keeps snoop_req low, and makes no access while bus_grant is low.
- R7: With the snoop bit at 1, the channel raises snoop_req, never raises bus_req, and ignores release_req even when release enable is set.
- R8: With the snoop bit at 0 and release enable at 1, a release_req seen during a unit lets that unit's accesses finish, then drops bus_req and makes no access. It asks for the bus again after release_req falls, and it resumes at the next addresses.
- R9: With release enable at 0, release_req has no effect and bus_req stays high until the transfer ends.
- R10: With the external-select bit at 0, a high int_req triggers each unit and the level bit is ignored. With external-select at 1, the level bit set to 1 makes a high ext_req trigger each unit. With the level bit at 0, each rising edge of ext_req triggers exactly one unit.
- R11: Exactly unit_count units are moved. done rises after the last write, stays high with no access or request until the next start, and clears on that start. A start with unit_count 0 sets done without any access.
- R12: The control fields are captured at start, and changes to them during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins a transfer when idle |
| cfg_level | input | 1 | External trigger works on level (1) or rising edge (0) |
| cfg_ext_sel | input | 1 | Use ext_req (1) or int_req (0) as the trigger |
| cfg_snoop | input | 1 | Snoop bus mode (1) or request/grant mode (0) |
| cfg_rel_en | input | 1 | Honour release_req in request/grant mode |
| cfg_src_io | input | 1 | Source is an I/O device |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_io | input | 1 | Destination is an I/O device |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_unit | input | 2 | Unit size per trigger |
| cfg_port | input | 2 | I/O port width |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| unit_count | input | CNT_W | Number of units to move |
| int_req | input | 1 | Internal trigger line |
| ext_req | input | 1 | External trigger line |
| bus_grant | input | 1 | Bus granted to the channel |
| release_req | input | 1 | Processor asks for the bus back |
| bus_req | output | 1 | Bus request, request/grant mode |
| snoop_req | output | 1 | Bus request, snoop mode |
| bus_addr | output | ADDR_W | Access address |
| bus_rd | output | 1 | Read access this cycle |
| bus_wr | output | 1 | Write access this cycle |
| bus_size | output | 2 | Access size |
| done | output | 1 | Transfer complete |

## Verification
The hardest case to reach is a release request that arrives in the middle of a unit that is being split into narrow writes. The bus must not be given up until the last part of that unit has been written. To get there, the bench waits until it logs the first narrow write of the first unit, and only then raises release_req. It checks that exactly one full unit was logged and that bus_req is low. It then lowers release_req and checks that the later accesses continue from the saved addresses. The edge-triggered external mode is a second hard case. The bench holds ext_req high for many cycles and checks that only one unit moves until the line falls and rises again.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } acc_sz_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_ARM,
      ST_RD,
      ST_WR,
      ST_YIELD
   } seq_st_e;

   typedef struct packed {
      logic       level_mode;
      logic       ext_sel;
      logic       snoop;
      logic       release_en;
      logic       src_io;
      logic [1:0] src_mode;
      logic       dst_io;
      logic [1:0] dst_mode;
      logic [1:0] unit_sz;
      logic [1:0] port_sz;
   } chan_cfg_t;

   // Field code to access size: 11 byte, 10 half, 0x word
   function automatic acc_sz_e width_code(input logic [1:0] f);
      case (f)
         2'b11:   return SZ_BYTE;
         2'b10:   return SZ_HALF;
         default: return SZ_WORD;
      endcase
   endfunction

   function automatic logic [2:0] sz_bytes(input acc_sz_e s);
      case (s)
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   // Access size used on one side of the transfer
   function automatic acc_sz_e side_sz(input logic is_io, input acc_sz_e unit,
                                       input acc_sz_e port);
      if (is_io && (port < unit)) return port;
      return unit;
   endfunction

   // Number of accesses per unit, minus one
   function automatic logic [1:0] beats_m1(input acc_sz_e unit, input acc_sz_e acc);
      logic [1:0] u;
      logic [1:0] a;
      logic [1:0] d;
      u = unit;
      a = acc;
      d = u - a;
      case (d)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   input  logic [1:0]        mode,
   input  logic [2:0]        step,
   output logic [ADDR_W-1:0] addr
);
   localparam int PAD_W = ADDR_W - 3;

   if (ADDR_W < 4) begin : g_bad_width
      $error("dma_addr_gen: ADDR_W must be at least 4");
   end

   logic [ADDR_W-1:0] step_w;
   assign step_w = {{PAD_W{1'b0}}, step};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= base;
      end else if (adv && !mode[1]) begin
         addr <= mode[0] ? (addr - step_w) : (addr + step_w);
      end
   end

endmodule

// File: rtl/dma_trig_unit.sv
module dma_trig_unit #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic consume,
   input  logic ext_sel,
   input  logic level_mode,
   input  logic int_req,
   input  logic ext_req,
   output logic fire
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("dma_trig_unit: SYNC_STAGES must be 0 to 4");
   end

   logic ext_s;

   if (SYNC_STAGES == 0) begin : g_direct
      assign ext_s = ext_req;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= SYNC_STAGES'({stg, ext_req});
      end
      assign ext_s = stg[SYNC_STAGES-1];
   end

   logic ext_d;
   logic pending;
   logic rise;

   assign rise = ext_s && !ext_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_d   <= 1'b0;
         pending <= 1'b0;
      end else begin
         ext_d <= ext_s;
         if (!active)      pending <= 1'b0;
         else if (rise)    pending <= 1'b1;
         else if (consume) pending <= 1'b0;
      end
   end

   always_comb begin
      if (!ext_sel)       fire = int_req;
      else if (level_mode) fire = ext_s;
      else                 fire = pending;
   end

endmodule

// File: rtl/dma_bus_owner.sv
module dma_bus_owner (
   input  logic want,
   input  logic snoop,
   input  logic release_en,
   input  logic release_req,
   input  logic grant,
   output logic bus_req,
   output logic snoop_req,
   output logic owned,
   output logic yield_ok
);
   assign bus_req   = want && !snoop;
   assign snoop_req = want && snoop;
   assign owned     = want && grant;
   assign yield_ok  = !snoop && release_en && release_req;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 16,
   parameter int EXT_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_level,
   input  logic              cfg_ext_sel,
   input  logic              cfg_snoop,
   input  logic              cfg_rel_en,
   input  logic              cfg_src_io,
   input  logic [1:0]        cfg_src_mode,
   input  logic              cfg_dst_io,
   input  logic [1:0]        cfg_dst_mode,
   input  logic [1:0]        cfg_unit,
   input  logic [1:0]        cfg_port,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [CNT_W-1:0]  unit_count,
   input  logic              int_req,
   input  logic              ext_req,
   input  logic              bus_grant,
   input  logic              release_req,
   output logic              bus_req,
   output logic              snoop_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [1:0]        bus_size,
   output logic              done
);
   localparam int NSIDE = 2;
   localparam int SRC   = 0;
   localparam int DST   = 1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("dma_chan_seq: CNT_W must be at least 1");
   end

   chan_cfg_t cfg_in;
   chan_cfg_t cfg_q;

   always_comb begin
      cfg_in.level_mode = cfg_level;
      cfg_in.ext_sel    = cfg_ext_sel;
      cfg_in.snoop      = cfg_snoop;
      cfg_in.release_en = cfg_rel_en;
      cfg_in.src_io     = cfg_src_io;
      cfg_in.src_mode   = cfg_src_mode;
      cfg_in.dst_io     = cfg_dst_io;
      cfg_in.dst_mode   = cfg_dst_mode;
      cfg_in.unit_sz    = cfg_unit;
      cfg_in.port_sz    = cfg_port;
   end

   seq_st_e          st;
   logic [1:0]       beat;
   logic [CNT_W-1:0] remaining;
   logic             done_q;

   // Access geometry of the captured configuration
   acc_sz_e    unit_e, port_e, src_sz, dst_sz;
   logic [1:0] src_last, dst_last;

   always_comb begin
      unit_e   = width_code(cfg_q.unit_sz);
      port_e   = width_code(cfg_q.port_sz);
      src_sz   = side_sz(cfg_q.src_io, unit_e, port_e);
      dst_sz   = side_sz(cfg_q.dst_io, unit_e, port_e);
      src_last = beats_m1(unit_e, src_sz);
      dst_last = beats_m1(unit_e, dst_sz);
   end

   // Bus ownership
   logic want, owned, yield_ok;

   assign want = (st == ST_ACQ) || (st == ST_ARM) || (st == ST_RD) || (st == ST_WR);

   dma_bus_owner u_owner (
      .want        (want),
      .snoop       (cfg_q.snoop),
      .release_en  (cfg_q.release_en),
      .release_req (release_req),
      .grant       (bus_grant),
      .bus_req     (bus_req),
      .snoop_req   (snoop_req),
      .owned       (owned),
      .yield_ok    (yield_ok)
   );

   // Trigger
   logic fire, consume, active;

   assign active  = (st != ST_IDLE);
   assign consume = (st == ST_ARM) && owned && fire;

   dma_trig_unit #(.SYNC_STAGES(EXT_SYNC)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .consume    (consume),
      .ext_sel    (cfg_q.ext_sel),
      .level_mode (cfg_q.level_mode),
      .int_req    (int_req),
      .ext_req    (ext_req),
      .fire       (fire)
   );

   // Address generators, one per side
   logic              load;
   logic [ADDR_W-1:0] side_base [NSIDE];
   logic [ADDR_W-1:0] side_addr [NSIDE];
   logic              side_adv  [NSIDE];
   logic [1:0]        side_mode [NSIDE];
   logic [2:0]        side_step [NSIDE];

   assign load = start && (st == ST_IDLE);

   always_comb begin
      side_base[SRC] = src_base;
      side_base[DST] = dst_base;
      side_adv[SRC]  = bus_rd;
      side_adv[DST]  = bus_wr;
      side_mode[SRC] = cfg_q.src_mode;
      side_mode[DST] = cfg_q.dst_mode;
      side_step[SRC] = sz_bytes(src_sz);
      side_step[DST] = sz_bytes(dst_sz);
   end

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      dma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load),
         .base  (side_base[s]),
         .adv   (side_adv[s]),
         .mode  (side_mode[s]),
         .step  (side_step[s]),
         .addr  (side_addr[s])
      );
   end

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         beat      <= '0;
         remaining <= '0;
         done_q    <= 1'b0;
         cfg_q     <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  cfg_q     <= cfg_in;
                  remaining <= unit_count;
                  beat      <= '0;
                  if (unit_count == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     done_q <= 1'b0;
                     st     <= ST_ACQ;
                  end
               end
            end
            ST_ACQ: begin
               if (owned) st <= ST_ARM;
            end
            ST_ARM: begin
               if (consume) begin
                  st   <= ST_RD;
                  beat <= '0;
               end
            end
            ST_RD: begin
               if (bus_grant) begin
                  if (beat == src_last) begin
                     beat <= '0;
                     st   <= ST_WR;
                  end else begin
                     beat <= beat + 2'd1;
                  end
               end
            end
            ST_WR: begin
               if (bus_grant) begin
                  if (beat == dst_last) begin
                     beat      <= '0;
                     remaining <= remaining - ONE;
                     if (remaining == ONE) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                     end else if (yield_ok) begin
                        st <= ST_YIELD;
                     end else begin
                        st <= ST_ARM;
                     end
                  end else begin
                     beat <= beat + 2'd1;
                  end
               end
            end
            ST_YIELD: begin
               if (!release_req) st <= ST_ACQ;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Bus outputs
   assign bus_rd   = (st == ST_RD) && bus_grant;
   assign bus_wr   = (st == ST_WR) && bus_grant;
   assign bus_addr = (st == ST_WR) ? side_addr[DST] : side_addr[SRC];
   assign bus_size = (st == ST_WR) ? dst_sz : src_sz;
   assign done     = done_q;

   // Captured fields seen by the checker
   logic snoop_q;
   logic src_fixed_q;
   assign snoop_q     = cfg_q.snoop;
   assign src_fixed_q = cfg_q.src_mode[1];

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              bus_req,
   input logic              snoop_req,
   input logic              bus_grant,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic              done,
   input logic              snoop_q,
   input logic              src_fixed_q
);
   // R6
   grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> bus_grant);

   // R4
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   // R7
   snoop_no_greq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_q |-> !bus_req);

   // R8
   release_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> $past(bus_wr));

   // R2
   fixed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && $past(bus_rd) && src_fixed_q) |-> $stable(bus_addr));

   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(bus_rd || bus_wr || bus_req || snoop_req));

   // R3
   size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> (bus_size != 2'b11));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_rd      (bus_rd),
   .bus_wr      (bus_wr),
   .bus_req     (bus_req),
   .snoop_req   (snoop_req),
   .bus_grant   (bus_grant),
   .bus_addr    (bus_addr),
   .bus_size    (bus_size),
   .done        (done),
   .snoop_q     (snoop_q),
   .src_fixed_q (src_fixed_q)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        c_level, c_ext, c_snoop, c_rel, c_sio, c_dio;
   logic [1:0]  c_smode, c_dmode, c_unit, c_port;
   logic [31:0] src_base, dst_base;
   logic [15:0] unit_count;
   logic        int_req, ext_req, bus_grant, release_req;
   logic        bus_req, snoop_req, bus_rd, bus_wr, done;
   logic [31:0] bus_addr;
   logic [1:0]  bus_size;
   logic        grant_en;

   always #4 clk = ~clk;

   dma_chan_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_level(c_level), .cfg_ext_sel(c_ext), .cfg_snoop(c_snoop), .cfg_rel_en(c_rel),
      .cfg_src_io(c_sio), .cfg_src_mode(c_smode), .cfg_dst_io(c_dio), .cfg_dst_mode(c_dmode),
      .cfg_unit(c_unit), .cfg_port(c_port),
      .src_base(src_base), .dst_base(dst_base), .unit_count(unit_count),
      .int_req(int_req), .ext_req(ext_req), .bus_grant(bus_grant), .release_req(release_req),
      .bus_req(bus_req), .snoop_req(snoop_req), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size), .done(done)
   );

   int checks = 0;
   int fails  = 0;

   bit          lg_wr    [64];
   int unsigned lg_addr  [64];
   int          lg_bytes [64];
   int          n_log = 0;
   bit          ex_wr    [64];
   int unsigned ex_addr  [64];
   int          ex_bytes [64];
   int          n_exp = 0;

   function automatic int size_out(input logic [1:0] s);
      case (s)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 4;
         default: return 0;
      endcase
   endfunction

   function automatic int fbytes(input logic [1:0] f);
      case (f)
         2'b11:   return 1;
         2'b10:   return 2;
         default: return 4;
      endcase
   endfunction

   function automatic int unsigned nxt(input int unsigned a, input logic [1:0] m, input int b);
      if (m[1]) return a;
      if (m[0]) return a - b;
      return a + b;
   endfunction

   // Access monitor and grant model
   always @(negedge clk) begin
      if (rst_n && (bus_rd || bus_wr) && n_log < 64) begin
         lg_wr[n_log]    = bus_wr;
         lg_addr[n_log]  = bus_addr;
         lg_bytes[n_log] = size_out(bus_size);
         n_log++;
      end
      bus_grant <= grant_en && (bus_req || snoop_req);
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic add_exp(input bit wr, input int unsigned a, input int b);
      ex_wr[n_exp]    = wr;
      ex_addr[n_exp]  = a;
      ex_bytes[n_exp] = b;
      n_exp++;
   endtask

   task automatic build_exp(input int unsigned sa0, input int unsigned da0, input int cnt);
      int unsigned sa = sa0;
      int unsigned da = da0;
      int ub = fbytes(c_unit);
      int pb = fbytes(c_port);
      int sb = (c_sio && pb < ub) ? pb : ub;
      int db = (c_dio && pb < ub) ? pb : ub;
      for (int u = 0; u < cnt; u++) begin
         for (int k = 0; k < ub / sb; k++) begin
            add_exp(1'b0, sa, sb);
            sa = nxt(sa, c_smode, sb);
         end
         for (int k = 0; k < ub / db; k++) begin
            add_exp(1'b1, da, db);
            da = nxt(da, c_dmode, db);
         end
      end
   endtask

   task automatic cmp_log(input string req);
      check(n_log == n_exp, req, "access count", n_log, n_exp);
      for (int i = 0; i < n_exp && i < n_log; i++) begin
         check(lg_wr[i] == ex_wr[i] && lg_addr[i] == ex_addr[i] && lg_bytes[i] == ex_bytes[i],
               req, $sformatf("access %0d wr/size %0d/%0d vs %0d/%0d addr",
                              i, lg_wr[i], lg_bytes[i], ex_wr[i], ex_bytes[i]),
               lg_addr[i], ex_addr[i]);
      end
   endtask

   task automatic set_cfg();
      c_level = 0; c_ext = 0; c_snoop = 0; c_rel = 0;
      c_sio = 0; c_dio = 0; c_smode = 2'b00; c_dmode = 2'b00;
      c_unit = 2'b00; c_port = 2'b00;
      int_req = 1; ext_req = 0; release_req = 0; grant_en = 1;
      n_log = 0; n_exp = 0;
   endtask

   task automatic kick(input int unsigned sa, input int unsigned da, input int cnt);
      src_base = sa; dst_base = da; unit_count = 16'(cnt);
      start = 1;
      tick();
      start = 0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 500) begin
         tick();
         n++;
      end
      check(done == 1'b1, req, "done after transfer", done, 1);
      tick();
   endtask

   task automatic t_reset();
      check(bus_rd == 0 && bus_wr == 0, "R1", "strobes after reset", {bus_rd, bus_wr}, 0);
      check(bus_req == 0 && snoop_req == 0, "R1", "requests after reset", {bus_req, snoop_req}, 0);
      check(done == 0, "R1", "done after reset", done, 0);
   endtask

   task automatic t_grant_wait();
      set_cfg();
      grant_en = 0;
      build_exp(32'h1000, 32'h2000, 3);
      kick(32'h1000, 32'h2000, 3);
      repeat (10) tick();
      check(bus_req == 1 && snoop_req == 0, "R6", "request while waiting", {bus_req, snoop_req}, 2);
      check(n_log == 0, "R6", "no access before grant", n_log, 0);
      grant_en = 1;
      wait_done("R11");
      cmp_log("R2 R3 R11 word inc");
      check(done == 1 && bus_req == 0, "R11", "done held idle", {done, bus_req}, 2);
   endtask

   task automatic t_modes();
      set_cfg();
      c_unit = 2'b10; c_smode = 2'b01; c_dmode = 2'b10;
      build_exp(32'h100, 32'h200, 2);
      kick(32'h100, 32'h200, 2);
      check(done == 0, "R11", "done cleared by start", done, 0);
      wait_done("R2");
      cmp_log("R2 half dec/fixed");
      set_cfg();
      c_unit = 2'b11; c_smode = 2'b11; c_dmode = 2'b01;
      build_exp(32'h340, 32'h480, 3);
      kick(32'h340, 32'h480, 3);
      wait_done("R2");
      cmp_log("R2 R3 byte fixed/dec");
   endtask

   task automatic t_split();
      set_cfg();
      c_dio = 1; c_port = 2'b11;
      build_exp(32'h5000, 32'h6000, 2);
      kick(32'h5000, 32'h6000, 2);
      wait_done("R4");
      cmp_log("R4 word to byte port");
      set_cfg();
      c_sio = 1; c_port = 2'b10; c_smode = 2'b10;
      build_exp(32'h7000, 32'h7100, 2);
      kick(32'h7000, 32'h7100, 2);
      wait_done("R4");
      cmp_log("R4 half port fixed source");
   endtask

   task automatic t_wide_port();
      set_cfg();
      c_unit = 2'b11; c_sio = 1; c_dio = 1; c_port = 2'b01;
      build_exp(32'h80, 32'h90, 2);
      kick(32'h80, 32'h90, 2);
      wait_done("R5");
      cmp_log("R5 byte unit on word port");
   endtask

   task automatic t_snoop();
      int greq_hi = 0;
      int sreq_hi = 0;
      set_cfg();
      c_snoop = 1; c_rel = 1; c_dio = 1; c_port = 2'b10;
      release_req = 1;
      build_exp(32'hA00, 32'hB00, 3);
      kick(32'hA00, 32'hB00, 3);
      for (int i = 0; i < 200 && !done; i++) begin
         if (bus_req) greq_hi++;
         if (snoop_req) sreq_hi++;
         tick();
      end
      check(greq_hi == 0, "R7", "bus_req cycles in snoop mode", greq_hi, 0);
      check(sreq_hi > 0, "R7", "snoop_req seen", sreq_hi, 1);
      check(done == 1, "R7", "done despite release_req", done, 1);
      cmp_log("R7 snoop transfer");
      release_req = 0;
   endtask

   task automatic t_release();
      int low = 0;
      set_cfg();
      c_rel = 1; c_dio = 1; c_port = 2'b11;
      build_exp(32'hC000, 32'hD000, 3);
      kick(32'hC000, 32'hD000, 3);
      for (int i = 0; i < 100 && n_log < 2; i++) tick();
      release_req = 1;
      repeat (10) tick();
      check(bus_req == 0, "R8", "bus released", bus_req, 0);
      check(n_log == 5, "R8", "whole unit before release", n_log, 5);
      release_req = 0;
      wait_done("R8");
      cmp_log("R8 resume after release");

      set_cfg();
      c_rel = 0; c_dio = 1; c_port = 2'b11;
      build_exp(32'hE000, 32'hE800, 3);
      kick(32'hE000, 32'hE800, 3);
      for (int i = 0; i < 100 && n_log < 2; i++) tick();
      release_req = 1;
      for (int i = 0; i < 200 && !done; i++) begin
         if (!bus_req) low++;
         tick();
      end
      check(low == 0, "R9", "bus_req low cycles with release disabled", low, 0);
      check(done == 1, "R9", "done", done, 1);
      cmp_log("R9 no release");
      release_req = 0;
   endtask

   task automatic t_trigger();
      set_cfg();
      c_ext = 1; c_level = 0; int_req = 1;
      build_exp(32'h300, 32'h400, 3);
      kick(32'h300, 32'h400, 3);
      repeat (4) tick();
      ext_req = 1;
      repeat (20) tick();
      check(n_log == 2, "R10", "one unit per edge", n_log, 2);
      ext_req = 0;
      repeat (2) tick();
      ext_req = 1;
      repeat (20) tick();
      check(n_log == 4, "R10", "second edge second unit", n_log, 4);
      ext_req = 0;
      tick();
      ext_req = 1;
      wait_done("R10");
      cmp_log("R10 edge triggered");

      set_cfg();
      c_ext = 1; c_level = 1; int_req = 0; ext_req = 1;
      build_exp(32'h600, 32'h700, 3);
      kick(32'h600, 32'h700, 3);
      wait_done("R10");
      cmp_log("R10 level external");

      set_cfg();
      c_ext = 0; c_level = 0; int_req = 0; ext_req = 1;
      build_exp(32'h900, 32'h980, 2);
      kick(32'h900, 32'h980, 2);
      repeat (10) tick();
      check(n_log == 0, "R10", "int_req low holds", n_log, 0);
      int_req = 1;
      wait_done("R10");
      cmp_log("R10 internal ignores level bit");
   endtask

   task automatic t_zero();
      set_cfg();
      kick(32'h10, 32'h20, 0);
      repeat (3) tick();
      check(done == 1, "R11", "done with zero count", done, 1);
      check(n_log == 0 && bus_req == 0, "R11", "no access with zero count", n_log, 0);
   endtask

   task automatic t_capture();
      set_cfg();
      build_exp(32'h2200, 32'h3300, 3);
      kick(32'h2200, 32'h3300, 3);
      c_smode = 2'b01; c_unit = 2'b11; c_snoop = 1; c_dio = 1; c_port = 2'b11;
      wait_done("R12");
      cmp_log("R12 fields captured at start");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      set_cfg();
      src_base = 0; dst_base = 0; unit_count = 0;
      bus_grant = 0;
      repeat (3) tick();
      t_reset();
      rst_n = 1;
      tick();
      t_reset();
      t_grant_wait();
      t_modes();
      t_split();
      t_wide_port();
      t_snoop();
      t_release();
      t_trigger();
      t_zero();
      t_capture();
      repeat (3) tick();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule